// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Hardware Flow Control

This block receives asynchronous serial frames on a single data line and hands each completed character to a host through a one-word buffer. The line first passes through a two-stage synchronizer. A falling edge starts a baud divider that runs at sixteen times the bit rate. The start bit is confirmed at its midpoint, and each later bit is taken at its centre. Bits arrive least significant first. They enter the top of a shift register, which moves right by one position per bit. When the stop bit has been sampled, the frame is copied into the buffer and a completion flag rises.

An active-low ready output (`rts_n_o`) throttles the far transmitter. It goes high as soon as a start bit is confirmed. It stays high until the host reads the low byte of the buffer. A transmitter that honours this line therefore never sends a character into a full buffer. Data length (7, 8 or 9 bits) and even or odd parity are selectable. Parity, framing and overrun errors are flagged. In interrupt mode 0, a one-cycle interrupt request pulse marks each completed frame.

Top module: `uart_rx_flow`

## Requirements
- R1: While `rx_en_i` is 0, no frame is received, `rx_done_o` does not rise and `rts_n_o` is held high.
- R2: One clock after `rx_en_i` changes from 0 to 1, `rts_n_o` is low.
- R3: While `rx_en_i` is 1, a `rd_lo_i` strobe drives `rts_n_o` low on the next clock, unless a start bit is confirmed in that same cycle.
- R4: When a start bit is confirmed at its midpoint, `rts_n_o` goes high. It stays high until the next `rd_lo_i` strobe.
- R5: A frame starts only on a high-to-low transition whose level is still low half a bit later. A low pulse shorter than half a bit is ignored, and `rts_n_o` is unchanged.
- R6: Data bits are received least significant first. `len_sel_i` = 0 selects 7 bits, 1 selects 8 bits, and 2 or 3 selects 9 bits. `rx_data_o` holds the character right-aligned with zeros above it.
- R7: On frame completion with `rx_done_o` low, the buffer is loaded and `rx_done_o` is set. A `rd_lo_i` strobe clears `rx_done_o` and `ovr_err_o`.
- R8: With `irq_mode_i` = 0, each completion that loads the buffer produces exactly one cycle of `irq_o`. With `irq_mode_i` = 1, no pulse is produced.
- R9: With `par_en_i` = 1, a parity bit follows the data. The parity bit is odd when `par_odd_i` = 1 and even otherwise. A mismatch sets `par_err_o` for that character.
- R10: A low level at the stop-bit centre sets `frm_err_o` for that character.
- R11: A frame that completes while `rx_done_o` is still set leaves `rx_data_o` unchanged and sets `ovr_err_o`.
- R12: After reset, `rts_n_o` is high, and `rx_done_o`, `irq_o` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial data line, idle high |
| rx_en_i | input | 1 | Receive enable |
| irq_mode_i | input | 1 | 0: interrupt pulse on completion, 1: no interrupt |
| len_sel_i | input | 2 | Data length select |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1 |
| rd_lo_i | input | 1 | Strobe: host reads buffer low byte |
| rx_data_o | output | 9 | Receive buffer |
| rx_done_o | output | 1 | Receive complete flag |
| par_err_o | output | 1 | Parity error of buffered character |
| frm_err_o | output | 1 | Framing error of buffered character |
| ovr_err_o | output | 1 | Overrun flag |
| rts_n_o | output | 1 | Ready to receive, active low |
| irq_o | output | 1 | Receive interrupt request pulse |

## Verification
The hardest state to reach is an overrun. A second full frame has to arrive while the first one is still unread. A well-behaved transmitter would be stopped by the ready line, so the bench acts as a sender that ignores `rts_n_o`. It sends two back-to-back frames with no read strobe between them. It then checks that the buffer still holds the first character and that the overrun flag is set. The glitch case is the other hard one. The bench drives a quarter-bit low pulse and confirms that neither the completion flag nor the ready line moves.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned OVS      = 16;
  localparam int unsigned MAX_BITS = 9;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  function automatic logic [3:0] len_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd7;
      2'd1:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rx_baud.sv
module rx_baud #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;

  assign tick_o = (cnt_q == LAST) && !restart_i;
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned DW = MAX_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic [3:0]    len_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          restart_o,
  output logic          start_ok_o,
  output logic          end_o,
  output logic [DW-1:0] data_o,
  output logic          par_err_o,
  output logic          frm_err_o
);
  rx_state_e     state_q;
  logic [3:0]    sub_q, bit_q;
  logic [DW-1:0] sh_q;
  logic          rxd_q, par_bad_q;
  logic          fall, mid, last;

  assign fall       = rxd_q & ~rxd_i;
  assign mid        = tick_i && (sub_q == 4'd7);
  assign last       = tick_i && (sub_q == 4'd15);
  assign restart_o  = en_i && (state_q == RX_IDLE) && fall;
  assign start_ok_o = en_i && (state_q == RX_START) && mid && !rxd_i;
  assign end_o      = en_i && (state_q == RX_STOP) && last;
  assign data_o     = sh_q >> (4'(DW) - len_i);
  assign par_err_o  = par_bad_q;
  assign frm_err_o  = !rxd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      sub_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      rxd_q     <= 1'b1;
      par_bad_q <= 1'b0;
    end else begin
      rxd_q <= rxd_i;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else begin
        if (tick_i) sub_q <= sub_q + 1'b1;
        case (state_q)
          RX_IDLE: if (fall) begin
            state_q <= RX_START;
            sub_q   <= '0;
          end
          RX_START: if (mid) begin
            if (!rxd_i) begin
              state_q   <= RX_DATA;
              sub_q     <= '0;
              bit_q     <= '0;
              par_bad_q <= 1'b0;
            end else begin
              state_q <= RX_IDLE;
            end
          end
          RX_DATA: if (last) begin
            sh_q  <= {rxd_i, sh_q[DW-1:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == len_i - 4'd1) state_q <= par_en_i ? RX_PAR : RX_STOP;
          end
          RX_PAR: if (last) begin
            par_bad_q <= rxd_i != ((^data_o) ^ par_odd_i);
            state_q   <= RX_STOP;
          end
          RX_STOP: if (last) state_q <= RX_IDLE;
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
  import uart_rx_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned DW      = MAX_BITS,
  parameter int unsigned SYNC    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          rx_en_i,
  input  logic          irq_mode_i,
  input  logic [1:0]    len_sel_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          rd_lo_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_done_o,
  output logic          par_err_o,
  output logic          frm_err_o,
  output logic          ovr_err_o,
  output logic          rts_n_o,
  output logic          irq_o
);
  logic          rxd_s, tick, restart, start_ok, frame_end, f_perr, f_ferr;
  logic [DW-1:0] f_data;
  logic          en_q;

  rx_sync #(.STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(rxd_s)
  );

  rx_baud #(.DIV(CLK_DIV)) u_baud (
    .clk_i, .rst_ni, .restart_i(restart), .tick_o(tick)
  );

  rx_frame #(.DW(DW)) u_frame (
    .clk_i, .rst_ni,
    .en_i       (rx_en_i),
    .rxd_i      (rxd_s),
    .tick_i     (tick),
    .len_i      (len_bits(len_sel_i)),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .restart_o  (restart),
    .start_ok_o (start_ok),
    .end_o      (frame_end),
    .data_o     (f_data),
    .par_err_o  (f_perr),
    .frm_err_o  (f_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      rts_n_o   <= 1'b1;
      rx_data_o <= '0;
      rx_done_o <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      ovr_err_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      en_q <= rx_en_i;
      // flow control: start of reception wins over a same-cycle read
      if (!rx_en_i || start_ok)       rts_n_o <= 1'b1;
      else if (!en_q || rd_lo_i)      rts_n_o <= 1'b0;

      irq_o <= frame_end && !rx_done_o && !irq_mode_i;
      if (frame_end) begin
        if (rx_done_o) begin
          ovr_err_o <= 1'b1;
        end else begin
          rx_data_o <= f_data;
          rx_done_o <= 1'b1;
          par_err_o <= f_perr && par_en_i;
          frm_err_o <= f_ferr;
        end
      end else if (rd_lo_i) begin
        rx_done_o <= 1'b0;
        ovr_err_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_flow_chk.sv
module uart_rx_flow_chk #(
  parameter int unsigned DW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic          rd_lo_i,
  input logic          start_ok,
  input logic          frame_end,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_done_o,
  input logic          rts_n_o,
  input logic          irq_o
);
  assert_disabled_rts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> rts_n_o);

  assert_read_rts_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i && rd_lo_i && !start_ok |=> !rts_n_o);

  assert_start_rts_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> rts_n_o);

  assert_read_clears_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i && !frame_end |=> !rx_done_o);

  assert_irq_with_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_done_o && !$past(rx_done_o));

  assert_overrun_keeps_buf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && rx_done_o |=> $stable(rx_data_o) && rx_done_o);
endmodule

bind uart_rx_flow uart_rx_flow_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_en_i   (rx_en_i),
  .rd_lo_i   (rd_lo_i),
  .start_ok  (start_ok),
  .frame_end (frame_end),
  .rx_data_o (rx_data_o),
  .rx_done_o (rx_done_o),
  .rts_n_o   (rts_n_o),
  .irq_o     (irq_o)
);

// File: tb/test_uart_rx_flow.sv
module test_uart_rx_flow;
  localparam int CLK_DIV = 4;
  localparam int BIT     = 16 * CLK_DIV;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rxd = 1'b1, rx_en = 1'b0, irq_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0, rd_lo = 1'b0;
  logic [1:0] len_sel = 2'd1;
  logic [8:0] rx_data;
  logic       rx_done, perr, ferr, ovr, rts_n, irq;

  int n_run = 0, n_fail = 0, irq_cnt = 0;
  logic [10:0] exp_q[$];
  logic prev_done = 1'b0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  uart_rx_flow #(.CLK_DIV(CLK_DIV)) i_uart_rx_flow (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .rx_en_i(rx_en),
    .irq_mode_i(irq_mode), .len_sel_i(len_sel), .par_en_i(par_en),
    .par_odd_i(par_odd), .rd_lo_i(rd_lo), .rx_data_o(rx_data),
    .rx_done_o(rx_done), .par_err_o(perr), .frm_err_o(ferr),
    .ovr_err_o(ovr), .rts_n_o(rts_n), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare each newly loaded character with the scoreboard
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (rx_done && !prev_done) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected load", int'(rx_data), 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e[10:2], "R6 data", int'(rx_data), int'(e[10:2]));
        chk(perr == e[1], "R9 parity flag", int'(perr), int'(e[1]));
        chk(ferr == e[0], "R10 framing flag", int'(ferr), int'(e[0]));
      end
    end
    prev_done = rx_done;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input bit bad_par,
                      input bit stop, input bit push);
    logic [8:0] m;
    m = d & 9'((1 << nb) - 1);
    if (push) exp_q.push_back({m, bad_par & par_en, ~stop});
    @(negedge clk);
    rxd = 1'b0; wait_clk(BIT);
    for (int i = 0; i < nb; i++) begin
      rxd = m[i]; wait_clk(BIT);
    end
    if (par_en) begin
      rxd = (^m) ^ par_odd ^ bad_par; wait_clk(BIT);
    end
    rxd = stop; wait_clk(BIT);
    rxd = 1'b1; wait_clk(BIT);
  endtask

  task automatic read_buf();
    rd_lo = 1'b1; wait_clk(1); rd_lo = 1'b0; wait_clk(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(3); rst_n = 1'b1; wait_clk(2);
    chk(rts_n && !rx_done && !irq && !perr && !ferr && !ovr, "R12 reset state",
        {rts_n, rx_done, irq, perr, ferr, ovr}, 6'b100000);

    send(9'h03c, 8, 0, 1, 0);
    chk(!rx_done, "R1 disabled no load", rx_done, 0);
    chk(rts_n, "R1 disabled rts high", rts_n, 1);

    rx_en = 1'b1; wait_clk(2);
    chk(!rts_n, "R2 enable rts low", rts_n, 0);

    send(9'h0a5, 8, 0, 1, 1);
    chk(rx_done, "R7 done set", rx_done, 1);
    chk(rts_n, "R4 rts high until read", rts_n, 1);
    chk(irq_cnt == 1, "R8 one irq pulse", irq_cnt, 1);
    read_buf();
    chk(!rx_done, "R7 read clears done", rx_done, 1'b0);
    chk(!rts_n, "R3 read drives rts low", rts_n, 0);

    len_sel = 2'd0; par_en = 1'b1; par_odd = 1'b0;
    send(9'h055, 7, 0, 1, 1); read_buf();
    len_sel = 2'd2; par_odd = 1'b1;
    send(9'h1c3, 9, 0, 1, 1); read_buf();
    len_sel = 2'd1; par_odd = 1'b0;
    send(9'h0f0, 8, 1, 1, 1); read_buf();
    par_en = 1'b0;
    send(9'h081, 8, 0, 0, 1); read_buf();

    send(9'h011, 8, 0, 1, 1);
    send(9'h022, 8, 0, 1, 0);
    chk(ovr, "R11 overrun flag", ovr, 1);
    chk(rx_data == 9'h011, "R11 buffer kept", int'(rx_data), 'h11);
    read_buf();
    chk(!ovr, "R7 read clears overrun", ovr, 0);

    irq_mode = 1'b1; irq_cnt = 0;
    send(9'h077, 8, 0, 1, 1);
    chk(irq_cnt == 0, "R8 no irq in mode 1", irq_cnt, 0);
    chk(rx_done, "R8 done still set", rx_done, 1);
    read_buf();

    rxd = 1'b0; wait_clk(BIT / 4); rxd = 1'b1; wait_clk(2 * BIT);
    chk(!rx_done, "R5 glitch ignored", rx_done, 0);
    chk(!rts_n, "R5 glitch rts unchanged", rts_n, 0);

    chk(exp_q.size() == 0, "R6 all frames seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule